// File: doc/BRIEF.md
# Decimal Counter with Sequence Watchdog

This block is a single-digit decimal counter that runs entirely on one free-running clock. On each enabled edge it steps up or down through the digits 0 to 9 and wraps at either end. It has a synchronous clear, a synchronous parallel load and a count enable that pauses it. When the enable is high and the digit is at the end of its range for the current direction, a terminal-count output goes high, so it can drive the enable of a following digit.

Alongside the counter sits a sequence monitor. A one-bit history register remembers whether the previous value was nine. A sticky alarm is raised when that history bit is set and the present value is ten (binary 1010). Normal counting never produces this jump. The parallel load can place any 4-bit value in the register, so a fault can be injected on purpose to exercise the monitor. A value of ten to fifteen loaded in any other context is not flagged.

Top module: `dec_counter_watch`

## Requirements
- R1: Reset is synchronous. On the edge where `rst` is high, `count` becomes 0, `alarm` becomes 0 and the nine-history bit is cleared. A 10 loaded directly after that edge raises no alarm, even if the value before reset was 9.
- R2: When `rst` is low and `load` is high, `count` takes `load_data` (any value 0 to 15) on the edge, whatever `en` and `up` are.
- R3: With `up`=1 (count up), an enabled edge takes a value v below 9 to v+1, and takes any value from 9 to 15 to 0. From reset, ten enabled edges go 1,2,...,9,0.
- R4: With `up`=0 (count down), an enabled edge takes 0 to 9 and any other value v to v-1.
- R5: When `rst`, `load` and `en` are all low, `count` holds its value across the edge.
- R6: Reset takes priority over load, and load takes priority over the count enable.
- R7: `tc` is 1 exactly when `en`=1 and either `up`=1 with `count`=9, or `up`=0 with `count`=0. Otherwise it is 0. It is combinational on the present inputs and state.
- R8: If `count` is 9 in one cycle and 10 in the next cycle, `alarm` goes to 1 on the following edge.
- R9: Once `alarm` is 1 it stays 1 through any counting or loading until a reset edge.
- R10: A value from 10 to 15 that does not come straight after a 9, or any value other than 10 that follows a 9, does not raise `alarm`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Single clock; every register samples on its rising edge |
| rst | input | 1 | Synchronous clear of count, history bit and alarm |
| load | input | 1 | Synchronous parallel load request |
| load_data | input | 4 | Value captured when loading |
| en | input | 1 | Count enable; low pauses the counter |
| up | input | 1 | Direction: 1 counts up, 0 counts down |
| count | output | 4 | Present counter value |
| tc | output | 1 | Terminal count for the current direction while enabled |
| alarm | output | 1 | Sticky flag for an observed 9-to-10 jump |

## Verification
The hardest state to reach is the alarm. Counting alone never goes from nine to ten, so the bench resets the block, loads a first value and then loads a second value on the very next edge. It then checks the alarm after one idle edge. It does this for all 256 ordered pairs of 4-bit values, so the single alarming pair and every near miss, such as ten not following nine or nine followed by eleven, are covered. A separate sequence loads 9 and then applies reset before loading 10. This shows that reset clears the history bit as well as the alarm.

// File: rtl/dec_counter_pkg.sv
package dec_counter_pkg;

    localparam int DEF_CNT_W      = 4;
    localparam int DEF_LAST_DIGIT = 9;
    localparam int DEF_FAULT_CODE = 10;

    typedef enum logic {
        DIR_DOWN = 1'b0,
        DIR_UP   = 1'b1
    } dir_e;

    typedef struct packed {
        logic seen_last;
        logic alarm;
    } mon_st_t;

endpackage

// File: rtl/dec_count_next.sv
module dec_count_next
    import dec_counter_pkg::*;
#(
    parameter int CNT_W      = DEF_CNT_W,
    parameter int LAST_DIGIT = DEF_LAST_DIGIT
) (
    input  logic [CNT_W-1:0] cnt,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_data,
    input  logic             en,
    input  logic             up,
    output logic [CNT_W-1:0] nxt,
    output logic             tc
);

    localparam logic [CNT_W-1:0] LAST_V = CNT_W'(LAST_DIGIT);
    localparam logic [CNT_W-1:0] ZERO_V = '0;
    localparam logic [CNT_W-1:0] ONE_V  = CNT_W'(1);

    dir_e dir;
    logic at_top;
    logic at_bottom;

    always_comb begin
        dir       = dir_e'(up);
        at_top    = (cnt >= LAST_V);
        at_bottom = (cnt == ZERO_V);
    end

    // Priority: clear, then load, then step, else hold.
    always_comb begin
        nxt = cnt;
        if (rst) begin
            nxt = ZERO_V;
        end else if (load) begin
            nxt = load_data;
        end else if (en) begin
            if (dir == DIR_UP) begin
                nxt = at_top ? ZERO_V : cnt + ONE_V;
            end else begin
                nxt = at_bottom ? LAST_V : cnt - ONE_V;
            end
        end
    end

    always_comb begin
        tc = en && (((dir == DIR_UP) && (cnt == LAST_V)) ||
                    ((dir == DIR_DOWN) && at_bottom));
    end

endmodule

// File: rtl/dec_seq_monitor.sv
module dec_seq_monitor
    import dec_counter_pkg::*;
#(
    parameter int CNT_W      = DEF_CNT_W,
    parameter int LAST_DIGIT = DEF_LAST_DIGIT,
    parameter int FAULT_CODE = DEF_FAULT_CODE
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] cnt,
    output logic             alarm
);

    localparam logic [CNT_W-1:0] LAST_V  = CNT_W'(LAST_DIGIT);
    localparam logic [CNT_W-1:0] FAULT_V = CNT_W'(FAULT_CODE);

    mon_st_t mon_d;
    mon_st_t mon_q;

    always_comb begin
        mon_d = mon_q;
        if (rst) begin
            mon_d = '0;
        end else begin
            mon_d.seen_last = (cnt == LAST_V);
            if (mon_q.seen_last && (cnt == FAULT_V)) begin
                mon_d.alarm = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        mon_q <= mon_d;
    end

    assign alarm = mon_q.alarm;

    // R9: alarm holds until a clear
    a_r9_alarm_sticky: assert property (@(posedge clk) disable iff (rst)
        alarm |=> alarm);

    // R8 / R10: alarm only rises after a nine followed by the fault code
    a_r8_alarm_needs_jump: assert property (@(posedge clk) disable iff (rst)
        $rose(alarm) |-> ($past(cnt) == FAULT_V) && ($past(cnt, 2) == LAST_V));

endmodule

// File: rtl/dec_counter_watch.sv
module dec_counter_watch
    import dec_counter_pkg::*;
#(
    parameter int CNT_W      = DEF_CNT_W,
    parameter int LAST_DIGIT = DEF_LAST_DIGIT,
    parameter int FAULT_CODE = DEF_FAULT_CODE
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_data,
    input  logic             en,
    input  logic             up,
    output logic [CNT_W-1:0] count,
    output logic             tc,
    output logic             alarm
);

    localparam logic [CNT_W-1:0] LAST_V = CNT_W'(LAST_DIGIT);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_st_t;

    cnt_st_t          st_d;
    cnt_st_t          st_q;
    logic [CNT_W-1:0] step_val;

    dec_count_next #(
        .CNT_W      (CNT_W),
        .LAST_DIGIT (LAST_DIGIT)
    ) u_next (
        .cnt       (st_q.cnt),
        .rst       (rst),
        .load      (load),
        .load_data (load_data),
        .en        (en),
        .up        (up),
        .nxt       (step_val),
        .tc        (tc)
    );

    always_comb begin
        st_d     = st_q;
        st_d.cnt = step_val;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign count = st_q.cnt;

    dec_seq_monitor #(
        .CNT_W      (CNT_W),
        .LAST_DIGIT (LAST_DIGIT),
        .FAULT_CODE (FAULT_CODE)
    ) u_mon (
        .clk   (clk),
        .rst   (rst),
        .cnt   (st_q.cnt),
        .alarm (alarm)
    );

    // R1, R6: a clear wins over everything
    a_r1_clear: assert property (@(posedge clk)
        rst |=> (count == '0) && !alarm);

    // R2: load captures data regardless of enable
    a_r2_load_capture: assert property (@(posedge clk) disable iff (rst)
        load |=> count == $past(load_data));

    // R5: paused counter holds
    a_r5_hold: assert property (@(posedge clk) disable iff (rst)
        (!load && !en) |=> $stable(count));

    // R3: upward wrap from the last digit
    a_r3_up_wrap: assert property (@(posedge clk) disable iff (rst)
        (!load && en && up && (count == LAST_V)) |=> (count == '0));

    // R4: downward wrap from zero
    a_r4_down_wrap: assert property (@(posedge clk) disable iff (rst)
        (!load && en && !up && (count == '0)) |=> (count == LAST_V));

endmodule

// File: tb/dec_counter_watch_bench.sv
module dec_counter_watch_bench;

    localparam int CLK_PERIOD = 10;
    localparam int W          = 4;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         load = 1'b0;
    logic [W-1:0] load_data = '0;
    logic         en = 1'b0;
    logic         up = 1'b1;
    logic [W-1:0] count;
    logic         tc;
    logic         alarm;

    int  checks = 0;
    int  failures = 0;
    bit  done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dec_counter_watch u_dec_counter_watch (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .load_data (load_data),
        .en        (en),
        .up        (up),
        .count     (count),
        .tc        (tc),
        .alarm     (alarm)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #(CLK_PERIOD/4);
    endtask

    task automatic drive(input bit r, input bit ld, input int d, input bit e, input bit u);
        rst       = r;
        load      = ld;
        load_data = W'(d);
        en        = e;
        up        = u;
        #1;
    endtask

    function automatic int step_of(input int v, input bit u);
        if (u) return (v >= 9) ? 0 : v + 1;
        return (v == 0) ? 9 : v - 1;
    endfunction

    initial begin
        int e;
        // R1: reset state
        drive(1, 0, 0, 0, 1);
        tick();
        tick();
        chk("R1 count after reset", int'(count), 0);
        chk("R1 alarm after reset", int'(alarm), 0);
        chk("R7 tc with enable low", int'(tc), 0);

        // R3: full upward run from zero
        drive(0, 0, 0, 1, 1);
        e = 0;
        for (int i = 0; i < 25; i++) begin
            chk("R7 tc while counting up", int'(tc), (e == 9) ? 1 : 0);
            tick();
            e = step_of(e, 1'b1);
            chk("R3 up sequence", int'(count), e);
            chk("R10 no alarm in normal counting", int'(alarm), 0);
        end

        // R4: full downward run
        drive(0, 0, 0, 1, 0);
        for (int i = 0; i < 25; i++) begin
            chk("R7 tc while counting down", int'(tc), (e == 0) ? 1 : 0);
            tick();
            e = step_of(e, 1'b0);
            chk("R4 down sequence", int'(count), e);
        end

        // R2, R3, R4, R5, R7: every start value in both directions
        for (int v = 0; v < 16; v++) begin
            for (int u = 0; u < 2; u++) begin
                drive(0, 1, v, 1, u[0]);
                tick();
                chk("R2 load over enable", int'(count), v);
                drive(0, 0, 0, 0, u[0]);
                chk("R7 tc low when paused", int'(tc), 0);
                tick();
                chk("R5 hold while paused", int'(count), v);
                drive(0, 0, 0, 1, u[0]);
                chk("R7 tc at range end", int'(tc),
                    ((u == 1 && v == 9) || (u == 0 && v == 0)) ? 1 : 0);
                tick();
                chk(u == 1 ? "R3 up step" : "R4 down step", int'(count), step_of(v, u[0]));
            end
        end

        // R6: reset beats load
        drive(0, 1, 7, 0, 1);
        tick();
        drive(1, 1, 5, 1, 1);
        tick();
        chk("R6 reset over load", int'(count), 0);

        // R8 / R10: every ordered pair of back-to-back loaded values
        for (int p = 0; p < 16; p++) begin
            for (int v = 0; v < 16; v++) begin
                drive(1, 0, 0, 0, 1);
                tick();
                drive(0, 1, p, 0, 1);
                tick();
                drive(0, 1, v, 0, 1);
                tick();
                drive(0, 0, 0, 0, 1);
                tick();
                chk((p == 9 && v == 10) ? "R8 alarm on 9 then 10" : "R10 no alarm",
                    int'(alarm), (p == 9 && v == 10) ? 1 : 0);
            end
        end

        // R9: sticky through counting and loading, cleared by reset
        drive(1, 0, 0, 0, 1);
        tick();
        drive(0, 1, 9, 0, 1);
        tick();
        drive(0, 1, 10, 0, 1);
        tick();
        drive(0, 0, 0, 1, 1);
        tick();
        chk("R8 alarm raised", int'(alarm), 1);
        for (int i = 0; i < 30; i++) begin
            drive(0, (i % 7) == 3, i % 16, 1, (i % 2) == 0);
            tick();
            chk("R9 alarm sticky", int'(alarm), 1);
        end
        drive(1, 0, 0, 0, 1);
        tick();
        chk("R9 reset clears alarm", int'(alarm), 0);

        // R1: reset also clears the nine-history bit
        drive(0, 1, 9, 0, 1);
        tick();
        drive(1, 0, 0, 0, 1);
        tick();
        drive(0, 1, 10, 0, 1);
        tick();
        drive(0, 0, 0, 0, 1);
        tick();
        chk("R1 reset clears history", int'(alarm), 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule